// File: doc/BRIEF.md
# Keyed Indexed Configuration Register File

This block holds the configuration state of a multi-function peripheral chip and exposes it to a host over a byte-wide I/O bus. Two bus addresses are decoded: a key/index port at a base chosen by a strap pin, and a data port one address above it. In the normal run state the register file is hidden. Two back-to-back writes of 0x55 to the key/index port open it, and a write of 0xAA to that port closes it again.

While the register file is open, the host writes an index byte to the key/index port and then reads or writes the selected register through the data port. A small set of global registers is shared. Every register at index 0x30 or above belongs to the bank of the logical device named by the device-select register at index 0x07. There are nine banks. Some registers exist only in particular banks.

Each bank drives its settings straight out to the peripheral functions: an activate bit, a 16-bit I/O base, a primary interrupt select, and a DMA select. The keyboard bank also drives a secondary interrupt select.

Top module: `keyed_cfg_top`

## Requirements
- R1: The block enters configuration mode only after two consecutive writes of 0x55 to the key/index port. It starts in run mode after reset.
- R2: Any other value written to the key/index port between the two 0x55 writes restarts key detection, so two further 0x55 writes are then needed.
- R3: In configuration mode, a write of 0xAA to the key/index port returns the block to run mode. Any other value written there becomes the current index.
- R4: With `strap_alt`=0 the key/index port is 0x03F0 and the data port is 0x03F1. With `strap_alt`=1 they are 0x0370 and 0x0371. Accesses to any other address are ignored, and a read of any other address returns 0xFF.
- R5: In run mode, data-port writes change nothing and data-port reads return 0xFF. The index is kept across lock and unlock.
- R6: Index 0x20 reads 0x02 (device identity). Index 0x21 reads the revision byte, which defaults to 0x01.
- R7: Index 0x07 holds the selected logical device number (0 to 8). Indexes 0x30 (activate, bit 0), 0x60 (base high byte), 0x61 (base low byte) and 0x70 (interrupt) are kept separately per device. If the number held is 9 or more, banked reads return 0x00 and banked writes are dropped.
- R8: Index 0x72 is present only in bank 7. Index 0x74 is present only in banks 0 and 3. In any other bank these indexes read 0x00, writes to them are dropped, and the matching export stays 0.
- R9: Index 0x22 reads {2'b00, activate bits of devices 5..0}, with device n at bit n. It is read-only.
- R10: Bank 0 has two readable and writable bytes, at indexes 0x90 and 0x91.
- R11: Unimplemented indexes read 0x00, and writes to them have no effect.
- R12: Reset clears the mode to run, the index, the device number and every banked register. All devices are therefore inactive.
- R13: The exports `dev_active`, `dev_base` ({high, low}), `dev_irq`, `dev_irq2` and `dev_dma` take their new value at the clock edge that captures the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the alternate port base 0x0370 |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational; 0xFF when not reading the open data port |
| dev_active | output | 9 | Activate bit per device |
| dev_base | output | 144 | 16-bit I/O base per device, device d at [16d+15:16d] |
| dev_irq | output | 72 | Primary interrupt select per device, device d at [8d+7:8d] |
| dev_irq2 | output | 8 | Secondary interrupt select of the keyboard device |
| dev_dma | output | 72 | DMA select per device, zero where absent |

## Verification
Data-port reads are combinational: the bench raises the read strobe after a falling edge and samples one nanosecond later, within the same cycle. Mode changes, index updates, device selection and every export take effect at the rising edge that captures the write. The bench therefore checks each of them one nanosecond after that edge. To confirm there is no extra delay, the bench samples an activate export before and after its capturing edge. Every check against the table is made by a read that follows the writes, so each write has settled before it is checked.

// File: rtl/lkcfg_pkg.sv
package lkcfg_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IX_DEVSEL = 8'h07;
  localparam logic [7:0] IX_IDENT  = 8'h20;
  localparam logic [7:0] IX_REV    = 8'h21;
  localparam logic [7:0] IX_PWR    = 8'h22;
  localparam logic [7:0] IX_BANK0  = 8'h30;
  localparam logic [7:0] IX_ACT    = 8'h30;
  localparam logic [7:0] IX_BHI    = 8'h60;
  localparam logic [7:0] IX_BLO    = 8'h61;
  localparam logic [7:0] IX_IRQ    = 8'h70;
  localparam logic [7:0] IX_IRQ2   = 8'h72;
  localparam logic [7:0] IX_DMA    = 8'h74;
  localparam logic [7:0] IX_FMODE  = 8'h90;
  localparam logic [7:0] IX_FOPT   = 8'h91;

  localparam logic [7:0] IDENT_VAL = 8'h02;

  typedef enum logic [1:0] {KS_RUN, KS_HALF, KS_CFG} key_st_e;

  function automatic logic [15:0] port_base(input logic alt);
    return alt ? 16'h0370 : 16'h03F0;
  endfunction

  function automatic logic is_banked(input logic [7:0] idx);
    return idx >= IX_BANK0;
  endfunction

  function automatic logic [7:0] pwr_byte(input logic [5:0] act);
    return {2'b00, act};
  endfunction
endpackage

// File: rtl/lkcfg_keydet.sv
module lkcfg_keydet
  import lkcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_mode,
  output logic       unlock_evt,
  output logic       lock_evt
);
  key_st_e st_q, st_d;

  assign unlock_evt = idx_wr && (st_q == KS_HALF) && (wdata == KEY_OPEN);
  assign lock_evt   = idx_wr && (st_q == KS_CFG)  && (wdata == KEY_CLOSE);
  assign cfg_mode   = (st_q == KS_CFG);

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KS_RUN:  if (wdata == KEY_OPEN) st_d = KS_HALF;
        KS_HALF: st_d = (wdata == KEY_OPEN) ? KS_CFG : KS_RUN;
        KS_CFG:  if (wdata == KEY_CLOSE) st_d = KS_RUN;
        default: st_d = KS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_RUN;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/lkcfg_bank.sv
module lkcfg_bank
  import lkcfg_pkg::*;
#(
  parameter bit HAS_IRQ2  = 1'b0,
  parameter bit HAS_DMA   = 1'b0,
  parameter bit HAS_FMODE = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        active,
  output logic [15:0] base,
  output logic [7:0]  irq,
  output logic [7:0]  irq2,
  output logic [7:0]  dma
);
  logic       act_q;
  logic [7:0] bhi_q, blo_q, irq_q;
  logic [7:0] fmode, fopt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bhi_q <= '0;
      blo_q <= '0;
      irq_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IX_ACT:  act_q <= wdata[0];
        IX_BHI:  bhi_q <= wdata;
        IX_BLO:  blo_q <= wdata;
        IX_IRQ:  irq_q <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_IRQ2) begin : g_irq2
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       q <= '0;
        else if (wr_en && idx == IX_IRQ2) q <= wdata;
      end
      assign irq2 = q;
    end else begin : g_no_irq2
      assign irq2 = '0;
    end

    if (HAS_DMA) begin : g_dma
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      q <= '0;
        else if (wr_en && idx == IX_DMA) q <= wdata;
      end
      assign dma = q;
    end else begin : g_no_dma
      assign dma = '0;
    end

    if (HAS_FMODE) begin : g_fmode
      logic [7:0] m_q, o_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          m_q <= '0;
          o_q <= '0;
        end else if (wr_en) begin
          if (idx == IX_FMODE) m_q <= wdata;
          if (idx == IX_FOPT)  o_q <= wdata;
        end
      end
      assign fmode = m_q;
      assign fopt  = o_q;
    end else begin : g_no_fmode
      assign fmode = '0;
      assign fopt  = '0;
    end
  endgenerate

  assign active = act_q;
  assign base   = {bhi_q, blo_q};
  assign irq    = irq_q;

  always_comb begin
    case (idx)
      IX_ACT:   rdata = {7'b0, act_q};
      IX_BHI:   rdata = bhi_q;
      IX_BLO:   rdata = blo_q;
      IX_IRQ:   rdata = irq_q;
      IX_IRQ2:  rdata = irq2;
      IX_DMA:   rdata = dma;
      IX_FMODE: rdata = fmode;
      IX_FOPT:  rdata = fopt;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_cfg_top.sv
module keyed_cfg_top
  import lkcfg_pkg::*;
#(
  parameter int         NUM_DEV  = 9,
  parameter int         KBD_DEV  = 7,
  parameter int         FDC_DEV  = 0,
  parameter int         PAR_DEV  = 3,
  parameter logic [7:0] REV_BYTE = 8'h01
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_alt,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [NUM_DEV*16-1:0] dev_base,
  output logic [NUM_DEV*8-1:0]  dev_irq,
  output logic [7:0]            dev_irq2,
  output logic [NUM_DEV*8-1:0]  dev_dma
);
  localparam int PWR_BITS = 6;

  logic [15:0] port_lo;
  logic        hit_idx, hit_dat;
  logic        idx_wr, dat_wr, dat_rd;
  logic        cfg_mode, unlock_evt, lock_evt;
  logic [7:0]  index_q, ldn_q;
  logic        ldn_ok;
  logic [7:0]  bank_sel_rd, cfg_rdata;
  logic [NUM_DEV-1:0] bank_we;
  logic [7:0]  bank_rd  [NUM_DEV];
  logic [7:0]  irq2_all [NUM_DEV];

  assign port_lo = port_base(strap_alt);
  assign hit_idx = (io_addr == port_lo);
  assign hit_dat = (io_addr == port_lo + 16'd1);
  assign idx_wr  = io_wr && hit_idx;
  assign dat_wr  = io_wr && hit_dat && cfg_mode;
  assign dat_rd  = io_rd && hit_dat;
  assign ldn_ok  = (ldn_q < 8'(NUM_DEV));

  lkcfg_keydet u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .wdata      (io_wdata),
    .cfg_mode   (cfg_mode),
    .unlock_evt (unlock_evt),
    .lock_evt   (lock_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && cfg_mode && !lock_evt)   index_q <= io_wdata;
      if (dat_wr && index_q == IX_DEVSEL)    ldn_q   <= io_wdata;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign bank_we[d] = dat_wr && is_banked(index_q) && (ldn_q == 8'(d));
    lkcfg_bank #(
      .HAS_IRQ2  (d == KBD_DEV),
      .HAS_DMA   ((d == FDC_DEV) || (d == PAR_DEV)),
      .HAS_FMODE (d == FDC_DEV)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_we[d]),
      .idx    (index_q),
      .wdata  (io_wdata),
      .rdata  (bank_rd[d]),
      .active (dev_active[d]),
      .base   (dev_base[d*16 +: 16]),
      .irq    (dev_irq[d*8 +: 8]),
      .irq2   (irq2_all[d]),
      .dma    (dev_dma[d*8 +: 8])
    );
  end

  always_comb begin
    bank_sel_rd = '0;
    dev_irq2    = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (ldn_q == 8'(d)) bank_sel_rd = bank_sel_rd | bank_rd[d];
      dev_irq2 = dev_irq2 | irq2_all[d];
    end
  end

  always_comb begin
    case (index_q)
      IX_DEVSEL: cfg_rdata = ldn_q;
      IX_IDENT:  cfg_rdata = IDENT_VAL;
      IX_REV:    cfg_rdata = REV_BYTE;
      IX_PWR:    cfg_rdata = pwr_byte(dev_active[PWR_BITS-1:0]);
      default:   cfg_rdata = (is_banked(index_q) && ldn_ok) ? bank_sel_rd : 8'h00;
    endcase
  end

  assign io_rdata = (dat_rd && cfg_mode) ? cfg_rdata : 8'hFF;
endmodule

// File: rtl/lkcfg_chk.sv
module lkcfg_chk #(
  parameter int NUM_DEV = 9
)(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mode,
  input logic               unlock_evt,
  input logic               idx_wr,
  input logic               dat_rd,
  input logic [7:0]         io_wdata,
  input logic [7:0]         io_rdata,
  input logic [7:0]         index_q,
  input logic [NUM_DEV-1:0] dev_active
);
  AST_RUN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !cfg_mode) |-> (io_rdata == 8'hFF)); // R5

  AST_RUN_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(dev_active)); // R5

  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && idx_wr && io_wdata == 8'hAA) |=> !cfg_mode); // R3

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(idx_wr && io_wdata == 8'h55)); // R1

  AST_OPEN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> cfg_mode); // R1

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && cfg_mode && index_q == 8'h20) |-> (io_rdata == 8'h02)); // R6

  AST_PWR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && cfg_mode && index_q == 8'h22) |-> (io_rdata[5:0] == dev_active[5:0] && io_rdata[7:6] == 2'b00)); // R9
endmodule

bind keyed_cfg_top lkcfg_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .unlock_evt (unlock_evt),
  .idx_wr     (idx_wr),
  .dat_rd     (dat_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .index_q    (index_q),
  .dev_active (dev_active)
);

// File: tb/sim_keyed_cfg_top.sv
`timescale 1ns/1ps
module sim_keyed_cfg_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strap_alt = 1'b0;
  logic [15:0]  io_addr = '0;
  logic         io_wr = 1'b0;
  logic         io_rd = 1'b0;
  logic [7:0]   io_wdata = '0;
  logic [7:0]   io_rdata;
  logic [8:0]   dev_active;
  logic [143:0] dev_base;
  logic [71:0]  dev_irq;
  logic [7:0]   dev_irq2;
  logic [71:0]  dev_dma;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  keyed_cfg_top u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
    .dev_irq2(dev_irq2), .dev_dma(dev_dma)
  );

  always #5 clk = ~clk;

  // entry: {req[3:0], is_read, on_data_port, wdata[7:0], expected[7:0]}
  localparam int NV = 63;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 1'b0,1'b0,8'h55,8'h00}, {4'd1, 1'b0,1'b0,8'h55,8'h00},   // R1 open
    {4'd6, 1'b0,1'b0,8'h20,8'h00}, {4'd6, 1'b1,1'b1,8'h00,8'h02},   // R6 ident
    {4'd6, 1'b0,1'b0,8'h21,8'h00}, {4'd6, 1'b1,1'b1,8'h00,8'h01},   // R6 revision
    {4'd7, 1'b0,1'b0,8'h07,8'h00}, {4'd7, 1'b0,1'b1,8'h04,8'h00},   // R7 select dev 4
    {4'd7, 1'b0,1'b0,8'h60,8'h00}, {4'd7, 1'b0,1'b1,8'h03,8'h00},
    {4'd7, 1'b0,1'b0,8'h61,8'h00}, {4'd7, 1'b0,1'b1,8'hF8,8'h00},
    {4'd7, 1'b0,1'b0,8'h70,8'h00}, {4'd7, 1'b0,1'b1,8'h04,8'h00},
    {4'd13,1'b0,1'b0,8'h30,8'h00}, {4'd13,1'b0,1'b1,8'h01,8'h00},
    {4'd7, 1'b0,1'b0,8'h61,8'h00}, {4'd7, 1'b1,1'b1,8'h00,8'hF8},   // R7 readback
    {4'd13,1'b0,1'b0,8'h30,8'h00}, {4'd13,1'b1,1'b1,8'h00,8'h01},   // R13 activate bit
    {4'd9, 1'b0,1'b0,8'h22,8'h00}, {4'd9, 1'b1,1'b1,8'h00,8'h10},   // R9 power byte
    {4'd8, 1'b0,1'b0,8'h07,8'h00}, {4'd8, 1'b0,1'b1,8'h07,8'h00},   // R8 keyboard
    {4'd8, 1'b0,1'b0,8'h72,8'h00}, {4'd8, 1'b0,1'b1,8'h0C,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h0C},
    {4'd8, 1'b0,1'b0,8'h07,8'h00}, {4'd8, 1'b0,1'b1,8'h04,8'h00},   // R8 absent in dev 4
    {4'd8, 1'b0,1'b0,8'h72,8'h00}, {4'd8, 1'b0,1'b1,8'h09,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h00},
    {4'd8, 1'b0,1'b0,8'h74,8'h00}, {4'd8, 1'b0,1'b1,8'h02,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h00},
    {4'd8, 1'b0,1'b0,8'h07,8'h00}, {4'd8, 1'b0,1'b1,8'h00,8'h00},   // R8 floppy DMA
    {4'd8, 1'b0,1'b0,8'h74,8'h00}, {4'd8, 1'b0,1'b1,8'h02,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h02},
    {4'd10,1'b0,1'b0,8'h90,8'h00}, {4'd10,1'b0,1'b1,8'h0E,8'h00},   // R10
    {4'd10,1'b1,1'b1,8'h00,8'h0E},
    {4'd10,1'b0,1'b0,8'h91,8'h00}, {4'd10,1'b0,1'b1,8'h5A,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'h5A},
    {4'd11,1'b0,1'b0,8'h25,8'h00}, {4'd11,1'b0,1'b1,8'h33,8'h00},   // R11
    {4'd11,1'b1,1'b1,8'h00,8'h00},
    {4'd5, 1'b0,1'b0,8'h61,8'h00}, {4'd3, 1'b0,1'b0,8'hAA,8'h00},   // R3 close
    {4'd5, 1'b1,1'b1,8'h00,8'hFF}, {4'd5, 1'b0,1'b1,8'h77,8'h00},   // R5 run mode
    {4'd5, 1'b0,1'b0,8'h55,8'h00}, {4'd5, 1'b0,1'b0,8'h55,8'h00},
    {4'd5, 1'b1,1'b1,8'h00,8'h00},
    {4'd2, 1'b0,1'b0,8'hAA,8'h00}, {4'd2, 1'b0,1'b0,8'h55,8'h00},   // R2 restart
    {4'd2, 1'b0,1'b0,8'h12,8'h00}, {4'd2, 1'b0,1'b0,8'h55,8'h00},
    {4'd2, 1'b1,1'b1,8'h00,8'hFF}, {4'd2, 1'b0,1'b0,8'h55,8'h00},
    {4'd2, 1'b1,1'b1,8'h00,8'h00}
  };

  function automatic logic [15:0] tb_base();
    return strap_alt ? 16'h0370 : 16'h03F0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    #1 io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    #1 io_rd = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
    wr(tb_base(), idx);
    rd(tb_base() + 16'd1, v);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset active", 32'(dev_active), 32'h0);
    chk("R12 reset base4", 32'(dev_base[64 +: 16]), 32'h0);
    rst_n = 1'b1;
    rd(16'h03F1, v);
    chk("R5 read before open", 32'(v), 32'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] e;
      e = VEC[i];
      if (e[17]) begin
        rd(tb_base() + 16'(e[16]), v);
        n_chk++;
        if (v !== e[7:0]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h", e[21:18], i, v, e[7:0]);
        end
      end else begin
        wr(tb_base() + 16'(e[16]), e[15:8]);
      end
    end

    // R13 exports after table
    chk("R13 base dev4", 32'(dev_base[64 +: 16]), 32'h03F8);
    chk("R13 irq dev4", 32'(dev_irq[32 +: 8]), 32'h04);
    chk("R8 irq2 kbd export", 32'(dev_irq2), 32'h0C);
    chk("R8 dma dev0 export", 32'(dev_dma[0 +: 8]), 32'h02);
    chk("R8 dma dev4 export", 32'(dev_dma[32 +: 8]), 32'h00);
    chk("R13 active vector", 32'(dev_active), 32'h010);

    // R13 timing: update lands at the capturing edge
    wr(16'h03F0, 8'h07); wr(16'h03F1, 8'h05); wr(16'h03F0, 8'h30);
    @(negedge clk);
    io_addr = 16'h03F1; io_wdata = 8'h01; io_wr = 1'b1;
    #1 chk("R13 before edge", 32'(dev_active[5]), 32'h0);
    @(posedge clk);
    #1 io_wr = 1'b0;
    chk("R13 after edge", 32'(dev_active[5]), 32'h1);

    // R9 read-only
    wr(16'h03F0, 8'h22); wr(16'h03F1, 8'hFF);
    rd(16'h03F1, v);
    chk("R9 power byte read-only", 32'(v), 32'h30);

    // R7 out-of-range device
    wr(16'h03F0, 8'h07); wr(16'h03F1, 8'h0C);
    wr(16'h03F0, 8'h30); wr(16'h03F1, 8'h01);
    rd(16'h03F1, v);
    chk("R7 bad device read", 32'(v), 32'h00);
    chk("R7 bad device no write", 32'(dev_active), 32'h030);
    reg_rd(8'h07, v);
    chk("R7 device number held", 32'(v), 32'h0C);

    // R4 other base ignored
    wr(16'h03F0, 8'hAA);
    wr(16'h0370, 8'h55); wr(16'h0370, 8'h55);
    rd(16'h03F1, v);
    chk("R4 alternate key ignored", 32'(v), 32'hFF);
    rd(16'h0371, v);
    chk("R4 alternate data ignored", 32'(v), 32'hFF);

    // R12 reset, then R4 alternate strap
    @(negedge clk);
    rst_n = 1'b0; strap_alt = 1'b1;
    #1;
    chk("R12 reset clears active", 32'(dev_active), 32'h0);
    chk("R12 reset clears irq2", 32'(dev_irq2), 32'h0);
    chk("R12 reset clears dma0", 32'(dev_dma[0 +: 8]), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(16'h0371, v);
    chk("R12 starts locked", 32'(v), 32'hFF);
    wr(16'h0370, 8'h55); wr(16'h0370, 8'h55);
    reg_rd(8'h20, v);
    chk("R4 alternate base ident", 32'(v), 32'h02);
    rd(16'h03F1, v);
    chk("R4 primary data ignored", 32'(v), 32'hFF);
    reg_rd(8'h07, v);
    chk("R12 device number cleared", 32'(v), 32'h00);
    reg_rd(8'h90, v);
    chk("R12 mode byte cleared", 32'(v), 32'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule